// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write Guard

This block is the bus side of a small serial EEPROM. It listens on a two-wire (I2C-compatible) bus whose clock and data lines reach it already synchronised to the system clock. It answers one fixed device address. In front of an internal 128-byte array it serves single-byte and page writes, and reads that are random, current-address or sequential. It pulls the data line low through an open-drain enable, and it pulses a flag each time it accepts a control byte, so that a neighbouring mode controller knows the bus side has taken over.

A write collects up to eight data bytes in a page buffer, which is tied to the eight-byte-aligned page of the start address. At the Stop condition, the buffered bytes that were actually received are committed to the array. A programming interval then follows, counted in system clocks. During that interval the block refuses its address, so a master can poll for completion. Two inputs gate each commit: a level enable that must be high, and an active-low protect pin. The protect pin only counts once the top location of the array has been written.

Top module: `e2_slave`

## Requirements
- R1: A control byte is accepted only when its upper seven bits equal 1010000. Bit 0 selects direction, with 1 meaning read and 0 meaning write. A control byte with any other address is not acknowledged, and the block then leaves SDA alone until the next Start.
- R2: For PROG_CYCLES clocks after a committing Stop, a control byte is not acknowledged. Once that interval has ended, a matching control byte is acknowledged again.
- R3: A byte write stores its data byte at the given word address. The sequence is a write control byte, then a word address, then one data byte, then Stop.
- R4: A page write places byte k at slot (start+k) mod 8 of the start address's aligned page. When more than eight bytes are sent, the later bytes overwrite the earlier ones. Only slots that received a byte are changed. A Stop that follows the word address with no data byte changes nothing and starts no programming interval.
- R5: A random read returns the byte stored at the word address that was set before a repeated Start. The sequence is a write control byte, a word address, a repeated Start, then a read control byte.
- R6: A read returns the byte at the internal pointer, and the pointer then advances by one. A current-address read returns the byte that follows the last one read. A sequential read continues while the master acknowledges, and wraps from 7Fh to 00h.
- R7: The block acknowledges every data byte of a write. If the level enable vclk is low at the Stop, the array is left unchanged and no programming interval starts.
- R8: wp_n has no effect until location 7Fh has been written. From then on, wp_n low at the Stop blocks the commit, and the array is left unchanged.
- R9: ctrl_ok is high for exactly one clock for each control byte that is acknowledged, and stays low otherwise.
- R10: While bus_en is low the block ignores the bus: SDA is released and no control byte is acknowledged.
- R11: sda_oe rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronised bus clock |
| sda_in | input | 1 | Synchronised bus data (wired line level) |
| wp_n | input | 1 | Active-low write protect, honoured once 7Fh has been written |
| vclk | input | 1 | Write enable level, must be high at Stop for a commit |
| bus_en | input | 1 | Enable from the mode controller |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ctrl_ok | output | 1 | One-clock pulse per accepted control byte |

## Verification
The assertions check on every clock the timing-level rules that need no knowledge of the array contents. These are the single-cycle shape of ctrl_ok and the fact that it never coincides with programming, that SDA is released while the block is disabled, that SDA is only pulled low during the low phase of SCL, and that no commit starts inside a running programming interval. What was stored, and where, can only be shown by the bench's scenarios, which compare full-array sequential reads against an arithmetic model. The same applies to page wrap and overwrite order, to gating by the enable level and the protect pin, to polling refusals and to pointer wrap.

// File: rtl/e2_pkg.sv
package e2_pkg;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_RX,
        BS_ACK,
        BS_TX,
        BS_MACK
    } bus_st_e;

    typedef enum logic [2:0] {
        SG_NONE,
        SG_CTRL,
        SG_ADDR,
        SG_DATA,
        SG_READ
    } stage_e;

endpackage

// File: rtl/e2_line_events.sv
module e2_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q, sda_q, scl_d, sda_d;

    always_comb begin
        scl_d = scl_in;
        sda_d = sda_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_rise = scl_in & ~scl_q;
    assign scl_fall = ~scl_in & scl_q;
    assign start_c  = scl_in & scl_q & sda_q & ~sda_in;
    assign stop_c   = scl_in & scl_q & ~sda_q & sda_in;
endmodule

// File: rtl/e2_prog_timer.sv
module e2_prog_timer #(
    parameter int PROG_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (launch)
            cnt_d = CNT_W'(PROG_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R2
    no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);
endmodule

// File: rtl/e2_store.sv
module e2_store #(
    parameter int ADDR_W     = 7,
    parameter int PAGE_BYTES = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_sel,
    input  logic [PAGE_BYTES-1:0][7:0]      wdata,
    input  logic [PAGE_BYTES-1:0]           wmask,
    input  logic [ADDR_W-1:0]               raddr,
    output logic [7:0]                      rdata
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int DEPTH  = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            for (int s = 0; s < PAGE_BYTES; s++)
                if (wmask[s]) mem[{page_sel, SLOT_W'(s)}] <= wdata[s];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/e2_slave.sv
module e2_slave #(
    parameter int         ADDR_W      = 7,
    parameter int         PAGE_BYTES  = 8,
    parameter int         PROG_CYCLES = 600,
    parameter logic [6:0] DEV_ID      = 7'b1010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wp_n,
    input  logic vclk,
    input  logic bus_en,
    output logic sda_oe,
    output logic ctrl_ok
);
    import e2_pkg::*;

    localparam int SLOT_W  = $clog2(PAGE_BYTES);
    localparam int PBASE_W = ADDR_W - SLOT_W;

    typedef struct packed {
        bus_st_e                   st;
        stage_e                    stg;
        logic [3:0]                cnt;
        logic [7:0]                sh;
        logic [7:0]                tx;
        logic [ADDR_W-1:0]         ptr;
        logic [PAGE_BYTES-1:0][7:0] pbuf;
        logic [PAGE_BYTES-1:0]     pmask;
        logic                      mack;
        logic                      oe;
        logic                      cok;
        logic                      armed;
    } fsm_t;

    fsm_t q, d;

    logic scl_rise, scl_fall, start_c, stop_c;
    logic busy, commit, wr_ok;
    logic [7:0] rdata;
    logic [SLOT_W-1:0] slot;

    e2_line_events u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    e2_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (commit),
        .busy   (busy)
    );

    e2_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .page_sel (q.ptr[ADDR_W-1:SLOT_W]),
        .wdata    (q.pbuf),
        .wmask    (q.pmask),
        .raddr    (q.ptr),
        .rdata    (rdata)
    );

    assign slot   = q.ptr[SLOT_W-1:0];
    assign wr_ok  = vclk && !(q.armed && !wp_n);
    assign commit = bus_en && stop_c && (q.stg == SG_DATA) && (|q.pmask) && wr_ok;

    always_comb begin
        d     = q;
        d.cok = 1'b0;
        if (!bus_en) begin
            d.st  = BS_IDLE;
            d.stg = SG_NONE;
            d.oe  = 1'b0;
        end else if (start_c) begin
            d.st  = BS_RX;
            d.stg = SG_CTRL;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else if (stop_c) begin
            d.st  = BS_IDLE;
            d.stg = SG_NONE;
            d.oe  = 1'b0;
            if (commit && (q.ptr[ADDR_W-1:SLOT_W] == {PBASE_W{1'b1}}) && q.pmask[PAGE_BYTES-1])
                d.armed = 1'b1;
        end else begin
            case (q.st)
                BS_RX: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_in};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        case (q.stg)
                            SG_CTRL: begin
                                if (q.sh[7:1] == DEV_ID && !busy) begin
                                    d.oe  = 1'b1;
                                    d.cok = 1'b1;
                                    d.st  = BS_ACK;
                                    d.stg = q.sh[0] ? SG_READ : SG_ADDR;
                                end else begin
                                    d.st  = BS_IDLE;
                                    d.stg = SG_NONE;
                                end
                            end
                            SG_ADDR: begin
                                d.ptr   = q.sh[ADDR_W-1:0];
                                d.pmask = '0;
                                d.oe    = 1'b1;
                                d.st    = BS_ACK;
                                d.stg   = SG_DATA;
                            end
                            SG_DATA: begin
                                d.pbuf[slot]  = q.sh;
                                d.pmask[slot] = 1'b1;
                                d.ptr[SLOT_W-1:0] = slot + SLOT_W'(1);
                                d.oe = 1'b1;
                                d.st = BS_ACK;
                            end
                            default: d.st = BS_IDLE;
                        endcase
                    end
                end
                BS_ACK: begin
                    if (scl_fall) begin
                        if (q.stg == SG_READ) begin
                            d.tx  = {rdata[6:0], 1'b0};
                            d.oe  = ~rdata[7];
                            d.cnt = 4'd1;
                            d.st  = BS_TX;
                        end else begin
                            d.oe  = 1'b0;
                            d.cnt = 4'd0;
                            d.st  = BS_RX;
                        end
                    end
                end
                BS_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe   = 1'b0;
                            d.ptr  = q.ptr + 1'b1;
                            d.mack = 1'b0;
                            d.st   = BS_MACK;
                        end else begin
                            d.oe  = ~q.tx[7];
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                BS_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_in;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.tx  = {rdata[6:0], 1'b0};
                            d.oe  = ~rdata[7];
                            d.cnt = 4'd1;
                            d.st  = BS_TX;
                        end else begin
                            d.st  = BS_IDLE;
                            d.stg = SG_NONE;
                        end
                    end
                end
                default: d.st = BS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= BS_IDLE;
            q.stg   <= SG_NONE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign ctrl_ok = q.cok;

    // R9
    cok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ok |=> !ctrl_ok);

    // R2
    cok_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ok |-> !busy);

    // R10
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> !sda_oe);

    // R11
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in);
endmodule

// File: tb/e2_slave_test.sv
module e2_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wp_n = 1'b1, vclk = 1'b1, bus_en = 1'b1;
    logic sda_oe, ctrl_ok;
    wire  line = sda_m & ~sda_oe;

    int total = 0, bad = 0, npulse = 0, exp_pulse = 0;
    logic [7:0] mem_m [128];
    logic [7:0] wbuf  [16];
    bit armed_m = 1'b0;

    always #4 clk = ~clk;

    e2_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(line),
        .wp_n(wp_n), .vclk(vclk), .bus_en(bus_en),
        .sda_oe(sda_oe), .ctrl_ok(ctrl_ok)
    );

    always @(negedge clk) if (ctrl_ok) npulse++;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = !line;
        scl_m = 1'b0; wq();
    endtask

    task automatic send_ctrl(input logic [7:0] b, output bit ack);
        send_byte(b, ack);
        if (ack) exp_pulse++;
    endtask

    task automatic recv_byte(input bit more, output logic [7:0] b);
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            scl_m = 1'b1; wq();
            b = {b[6:0], line};
            scl_m = 1'b0; wq();
        end
        sda_m = more ? 1'b0 : 1'b1; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic write_op(input logic [6:0] a, input int n, input string tag);
        bit ack, ok;
        ok = vclk && !(armed_m && !wp_n);
        bus_start();
        send_ctrl(8'hA0, ack); chk({tag, " ctrl ack"}, ack, 1);
        send_byte({1'b0, a}, ack); chk({tag, " addr ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            chk("R7 data ack", ack, 1);
        end
        bus_stop();
        if (ok && n > 0) begin
            for (int k = 0; k < n; k++) begin
                logic [6:0] t;
                t = {a[6:3], 3'(a[2:0] + 3'(k))};
                mem_m[t] = wbuf[k];
                if (t == 7'h7F) armed_m = 1'b1;
            end
            bus_start(); send_ctrl(8'hA0, ack); bus_stop();
            chk("R2 busy nack", ack, 0);
            for (int p = 0; p < 20 && !ack; p++) begin
                bus_start(); send_ctrl(8'hA0, ack); bus_stop();
            end
            chk("R2 ack after interval", ack, 1);
        end else begin
            bus_start(); send_ctrl(8'hA0, ack); bus_stop();
            chk({tag, " no interval"}, ack, 1);
        end
    endtask

    task automatic rand_read(input logic [6:0] a, output logic [7:0] b);
        bit ack;
        bus_start();
        send_ctrl(8'hA0, ack); chk("R5 ctrl ack", ack, 1);
        send_byte({1'b0, a}, ack); chk("R5 addr ack", ack, 1);
        bus_start();
        send_ctrl(8'hA1, ack); chk("R5 read ack", ack, 1);
        recv_byte(1'b0, b);
        bus_stop();
    endtask

    task automatic sweep(input logic [6:0] a, input int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_ctrl(8'hA0, ack); send_byte({1'b0, a}, ack);
        bus_start();
        send_ctrl(8'hA1, ack); chk("R6 sweep ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk("R6 sweep data", b, mem_m[7'(a + 7'(i))]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < 128; i++) mem_m[i] = 8'h00;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        wq();
        chk("R10 reset sda_oe", sda_oe, 0);
        chk("R9 reset ctrl_ok", ctrl_ok, 0);

        // R1 wrong addresses
        bus_start(); send_ctrl(8'hA2, ack); bus_stop(); chk("R1 nack A2", ack, 0);
        bus_start(); send_ctrl(8'h20, ack); bus_stop(); chk("R1 nack 20", ack, 0);
        chk("R9 no pulse on mismatch", npulse, exp_pulse);

        // R3 byte write
        wbuf[0] = 8'h3C;
        write_op(7'h05, 1, "R3");
        rand_read(7'h05, b); chk("R3 R5 read back", b, 8'h3C);

        // R4 page write with overflow
        for (int k = 0; k < 11; k++) wbuf[k] = 8'h80 + 8'(k);
        write_op(7'h12, 11, "R4");
        for (int k = 0; k < 3; k++) wbuf[k] = 8'hC0 + 8'(k);
        write_op(7'h31, 3, "R4");
        write_op(7'h44, 0, "R4");
        sweep(7'h00, 130);

        // R6 current address read
        rand_read(7'h12, b); chk("R5 page read", b, mem_m[7'h12]);
        bus_start(); send_ctrl(8'hA1, ack); recv_byte(1'b0, b); bus_stop();
        chk("R6 current read", b, mem_m[7'h13]);

        // R7 blocked by vclk
        vclk = 1'b0; wbuf[0] = 8'h77;
        write_op(7'h40, 1, "R7");
        vclk = 1'b1;
        rand_read(7'h40, b); chk("R7 unchanged", b, 8'h00);

        // R8 protect pin
        wp_n = 1'b0; wbuf[0] = 8'h5A;
        write_op(7'h41, 1, "R8");
        rand_read(7'h41, b); chk("R8 before arm", b, 8'h5A);
        wp_n = 1'b1; wbuf[0] = 8'hEE;
        write_op(7'h7F, 1, "R8");
        wp_n = 1'b0; wbuf[0] = 8'h99;
        write_op(7'h42, 1, "R8");
        rand_read(7'h42, b); chk("R8 blocked", b, 8'h00);
        wp_n = 1'b1;
        write_op(7'h42, 1, "R8");
        rand_read(7'h42, b); chk("R8 released", b, 8'h99);

        // R10 disabled bus
        bus_en = 1'b0;
        bus_start(); send_ctrl(8'hA0, ack); bus_stop();
        chk("R10 ignored", ack, 0);
        bus_en = 1'b1;
        wq();

        sweep(7'h7E, 130);
        chk("R9 pulse count", npulse, exp_pulse);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule